// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank SDRAM. After reset it holds the memory in a quiet power-up wait. Through that wait the clock enable and both byte masks stay high and the chip is deselected. It then issues a fixed bring-up program: precharge of both banks, a configurable number of auto-refresh commands, and a load of the mode register. Each command is followed by its own minimum gap, filled with no-operation commands. When the last gap has elapsed the block raises `ready`, releases the byte masks and hands the command pins to normal traffic.

From then on an interval timer counts the refresh period. The period is derived from the clock frequency and targets 4096 refreshes per 64 ms. Each time the period expires the block adds one to a count of owed refreshes, which has an upper limit. While any refresh is owed and no refresh is running, the block raises `ref_req` to the user arbiter. A grant seen together with the request makes the block issue one auto-refresh on the following cycle, pay off one owed refresh, and keep the pins on no-operation for the refresh recovery time. The arbiter may postpone refreshes, and the owed count lets the block catch up on them later.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: For PWRUP_CYC = CLK_MHZ*POWERUP_US cycles after reset release (and during reset), the block drives deselect (cs_n,ras_n,cas_n,we_n = 1,1,1,1), cke = 1, dqm = 2'b11, addr = 0, with ready and ref_req low.
- R2: In cycle PWRUP_CYC it issues precharge-all: cs_n,ras_n,cas_n,we_n = 0,0,1,0 with addr bit 10 set and all other address bits zero.
- R3: INIT_REFS auto-refresh commands (0,0,0,1, addr 0) follow. The first comes T_RP_CYC cycles after the precharge and each further one comes T_RC_CYC cycles after the one before. All gap cycles carry no-operation (0,1,1,1) with dqm still 2'b11.
- R4: A mode register set (0,0,0,0) comes T_RC_CYC cycles after the last initial refresh. The address carries the burst length code in bits 2:0, interleaved order in bit 3, CAS latency in bits 6:4 and single-write in bit 9, with every other bit zero.
- R5: ready rises T_MRD_CYC cycles after the mode register set and then stays high. dqm becomes 2'b00 in the same cycle.
- R6: Once ready is high, the owed-refresh count grows by one every REF_CYC = CLK_MHZ*REF_INTERVAL_NS/1000 cycles. The first increment takes effect REF_CYC cycles after ready rises.
- R7: ref_req is high exactly when ready is high, at least one refresh is owed and no refresh is in progress.
- R8: A cycle with ref_req and ref_gnt both high is followed by an auto-refresh command in the next cycle and removes one owed refresh. T_RC_CYC-1 no-operation cycles with ref_req low follow before the block can accept another grant.
- R9: ref_gnt while ref_req is low has no effect: no command is issued and the owed count does not change.
- R10: The owed count saturates at MAX_OWED. Further expiries while it is full are dropped.
- R11: If the interval expires in the same cycle that a grant is accepted, the owed count stays the same.
- R12: After ready, the command pins carry only no-operation or auto-refresh, and cke stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh |
| ref_req | output | 1 | Refresh owed and block free to issue it |
| ready | output | 1 | Bring-up complete, memory usable |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Byte masks, upper and lower |
| sd_addr | output | 12 | Address bus: precharge-all flag on bit 10, mode word during mode set |

## Verification
Two things can happen in one clock edge: the refresh interval can expire, and the arbiter's grant can be accepted. The expiry adds one owed refresh and the grant removes one. The bench provokes this on purpose. It withholds grants until the owed count is full, then asserts the grant only in the cycles where its own model says the interval timer wraps. It does this both at the saturation limit and later with a single refresh owed. A behavioural model tracks the owed count, the timer and the recovery window, and the outputs are compared against it on every cycle. Any wrong net change in the owed count shows up in the number of refreshes issued and in the timing of `ref_req`.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PALL,
        ST_PALL_GAP,
        ST_IREF,
        ST_IREF_GAP,
        ST_MRS,
        ST_MRS_GAP,
        ST_IDLE,
        ST_AREF,
        ST_AREF_GAP
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_DESL = 4'b1111;
    localparam sd_cmd_t CMD_NOP  = 4'b0111;
    localparam sd_cmd_t CMD_PALL = 4'b0010;
    localparam sd_cmd_t CMD_REF  = 4'b0001;
    localparam sd_cmd_t CMD_MRS  = 4'b0000;

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W           = 12,
    parameter int CAS_LAT          = 2,
    parameter int BURST_LEN_CODE   = 3,
    parameter int BURST_INTERLEAVE = 0,
    parameter int SINGLE_WRITE     = 0
) (
    output logic [ADDR_W-1:0] word
);
    // single-write flag, two zero bits, latency, order, length code
    localparam logic [9:0] MODE_BITS = {1'(SINGLE_WRITE), 2'b00, 3'(CAS_LAT),
                                        1'(BURST_INTERLEAVE), 3'(BURST_LEN_CODE)};

    assign word = ADDR_W'(MODE_BITS);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REF_CYC  = 1953,
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic take,
    output logic owed_any
);
    localparam int RW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
    localparam int OW = $clog2(MAX_OWED + 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic [OW-1:0] owed;
    } tmr_regs_t;

    tmr_regs_t   q, d;
    logic        expire;
    logic [OW:0] sum;

    always_comb begin
        d      = q;
        expire = enable && (q.cnt == '0);
        sum    = {1'b0, q.owed} + (OW+1)'(expire) - (OW+1)'(take && (q.owed != '0));
        if (enable) begin
            d.cnt = expire ? RW'(REF_CYC - 1) : q.cnt - 1'b1;
        end
        d.owed = (sum > (OW+1)'(MAX_OWED)) ? OW'(MAX_OWED) : sum[OW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= RW'(REF_CYC - 1);
            q.owed <= '0;
        end else begin
            q <= d;
        end
    end

    assign owed_any = (q.owed != '0);

    // R10
    owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.owed <= OW'(MAX_OWED));

    // R11
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && take) |=> $stable(q.owed));

    // R6
    expire_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !take) |=> (q.owed != '0));
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_MHZ          = 125,
    parameter int POWERUP_US       = 100,
    parameter int REF_INTERVAL_NS  = 15625,
    parameter int T_RP_CYC         = 3,
    parameter int T_RC_CYC         = 9,
    parameter int T_MRD_CYC        = 2,
    parameter int INIT_REFS        = 2,
    parameter int CAS_LAT          = 2,
    parameter int BURST_LEN_CODE   = 3,
    parameter int BURST_INTERLEAVE = 0,
    parameter int SINGLE_WRITE     = 0,
    parameter int MAX_OWED         = 8,
    parameter int ADDR_W           = 12,
    parameter int PRE_ALL_BIT      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_dqm,
    output logic [ADDR_W-1:0] sd_addr
);
    localparam int PWRUP_CYC = CLK_MHZ * POWERUP_US;
    localparam int REF_CYC   = CLK_MHZ * REF_INTERVAL_NS / 1000;
    localparam int GAP_MAX   = (T_RC_CYC > T_RP_CYC) ?
                               ((T_RC_CYC > T_MRD_CYC) ? T_RC_CYC : T_MRD_CYC) :
                               ((T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC);
    localparam int CNT_MAX   = (PWRUP_CYC > GAP_MAX) ? PWRUP_CYC : GAP_MAX;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int IREF_W    = $clog2(INIT_REFS + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IREF_W-1:0] irefs;
        logic              rdy;
    } seq_regs_t;

    seq_regs_t         q, d;
    sd_cmd_t           cmd;
    logic [ADDR_W-1:0] mode_word;
    logic              owed_any;
    logic              accept;

    sdram_mode_word #(
        .ADDR_W          (ADDR_W),
        .CAS_LAT         (CAS_LAT),
        .BURST_LEN_CODE  (BURST_LEN_CODE),
        .BURST_INTERLEAVE(BURST_INTERLEAVE),
        .SINGLE_WRITE    (SINGLE_WRITE)
    ) u_mode (
        .word(mode_word)
    );

    sdram_refresh_timer #(
        .REF_CYC (REF_CYC),
        .MAX_OWED(MAX_OWED)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (q.rdy),
        .take    (accept),
        .owed_any(owed_any)
    );

    assign ref_req = owed_any && q.rdy && (q.st == ST_IDLE);
    assign accept  = ref_req && ref_gnt;

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            ST_PWRUP: begin
                if (q.cnt == '0) d.st = ST_PALL;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_PALL: begin
                d.st  = ST_PALL_GAP;
                d.cnt = CNT_W'(T_RP_CYC - 2);
            end
            ST_PALL_GAP: begin
                if (q.cnt == '0) d.st = ST_IREF;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_IREF: begin
                d.st    = ST_IREF_GAP;
                d.cnt   = CNT_W'(T_RC_CYC - 2);
                d.irefs = q.irefs + 1'b1;
            end
            ST_IREF_GAP: begin
                if (q.cnt == '0) d.st = (q.irefs == IREF_W'(INIT_REFS)) ? ST_MRS : ST_IREF;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_MRS: begin
                d.st  = ST_MRS_GAP;
                d.cnt = CNT_W'(T_MRD_CYC - 2);
            end
            ST_MRS_GAP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_IDLE;
                    d.rdy = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (accept) d.st = ST_AREF;
            end
            ST_AREF: begin
                d.st  = ST_AREF_GAP;
                d.cnt = CNT_W'(T_RC_CYC - 2);
            end
            ST_AREF_GAP: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_PWRUP;
            q.cnt   <= CNT_W'(PWRUP_CYC - 1);
            q.irefs <= '0;
            q.rdy   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // pin decode from registered state
    always_comb begin
        sd_addr = '0;
        unique case (q.st)
            ST_PWRUP:         cmd = CMD_DESL;
            ST_PALL: begin
                cmd                  = CMD_PALL;
                sd_addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_IREF, ST_AREF: cmd = CMD_REF;
            ST_MRS: begin
                cmd     = CMD_MRS;
                sd_addr = mode_word;
            end
            default:          cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_cke   = 1'b1;
    assign sd_dqm   = q.rdy ? 2'b00 : 2'b11;
    assign ready    = q.rdy;

    // R2
    first_cmd_pall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sd_cs_n) && !ready) |-> (cmd == CMD_PALL && sd_addr[PRE_ALL_BIT]));

    // R3
    init_ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && cmd == CMD_REF) |=> (cmd == CMD_NOP));

    // R5
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R8
    grant_issues_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (cmd == CMD_REF));

    // R7
    busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd == CMD_REF) |=> !ref_req);
endmodule

// File: tb/tb_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_refresh_seq;
    localparam int P        = 125 * 100;
    localparam int I        = 125 * 15625 / 1000;
    localparam int T_RP     = 3;
    localparam int T_RC     = 9;
    localparam int T_MRD    = 2;
    localparam int NREF     = 2;
    localparam int MAXO     = 8;
    localparam int MODE     = (0 << 9) | (2 << 4) | (0 << 3) | 3;
    localparam int T_MRS    = P + T_RP + NREF * T_RC;
    localparam int T_READY  = T_MRS + T_MRD;
    localparam int END_N    = T_READY + 35 * I;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_gnt;
    logic        ref_req, ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_dqm;
    logic [11:0] sd_addr;

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    sdram_init_refresh_seq dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ready(ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [18:0] pins(input logic [3:0] c, input logic [1:0] m, input logic [11:0] a);
        return {1'b1, c, m, a};
    endfunction

    // behavioural model state
    int        n;
    int        m_debt, m_tick, m_busy;
    int        coinc, sat_hits;
    bit        prev_ign, prev_coinc;
    logic [15:0] lfsr;

    initial begin
        logic [18:0] got_v, exp_v;
        string       tag;
        bit          exp_req, expire, take, g;
        int          k;
        rst_n = 1'b0; ref_gnt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            got_v = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_addr};
            chk(got_v == pins(4'b1111, 2'b11, 12'h0), "R1 reset pins", 32'(got_v), 32'(pins(4'b1111, 2'b11, 12'h0)));
            chk(!ready && !ref_req, "R1 reset ready/req", {30'd0, ready, ref_req}, 32'd0);
        end
        rst_n = 1'b1;
        n = 0; m_debt = 0; m_tick = I - 1; m_busy = 0;
        coinc = 0; sat_hits = 0; prev_ign = 0; prev_coinc = 0; lfsr = 16'hACE1;
        while (n < END_N && !done) begin
            // expected pins for state n
            if (n < P) begin
                exp_v = pins(4'b1111, 2'b11, 12'h0); tag = "R1";
            end else if (n == P) begin
                exp_v = pins(4'b0010, 2'b11, 12'h400); tag = "R2";
            end else if (n < T_MRS) begin
                if (n >= P + T_RP && ((n - P - T_RP) % T_RC) == 0) exp_v = pins(4'b0001, 2'b11, 12'h0);
                else exp_v = pins(4'b0111, 2'b11, 12'h0);
                tag = "R3";
            end else if (n == T_MRS) begin
                exp_v = pins(4'b0000, 2'b11, 12'(MODE)); tag = "R4";
            end else if (n < T_READY) begin
                exp_v = pins(4'b0111, 2'b11, 12'h0); tag = "R4";
            end else begin
                exp_v = (m_busy == T_RC) ? pins(4'b0001, 2'b00, 12'h0) : pins(4'b0111, 2'b00, 12'h0);
                tag = prev_ign ? "R9" : (m_busy == T_RC) ? "R8" : prev_coinc ? "R11" : "R12";
            end
            got_v = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_addr};
            chk(got_v == exp_v, tag, 32'(got_v), 32'(exp_v));
            chk(ready == (n >= T_READY), "R5 ready", 32'(ready), 32'(n >= T_READY));
            exp_req = (n >= T_READY) && (m_debt > 0) && (m_busy == 0);
            chk(ref_req == exp_req, (m_debt == MAXO) ? "R10 req" : "R7 req", 32'(ref_req), 32'(exp_req));
            if (n >= T_READY && m_debt == 1 && m_tick == I - 1 && m_busy == 0)
                chk(ref_req == 1'b1, "R6 first owed", 32'(ref_req), 32'd1);

            // choose grant for the coming edge
            k = n - T_READY;
            if (k < 6 * I + 100)       g = 1'b1;
            else if (k < 17 * I)       g = 1'b0;
            else if (k < 21 * I)       g = (m_tick == 0);
            else if (k < 31 * I)       g = lfsr[0] & lfsr[3];
            else                       g = (m_tick == 0);
            ref_gnt = g;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

            // advance model by one edge
            prev_ign = g && !exp_req && (n >= T_READY);
            prev_coinc = 1'b0;
            if (n >= T_READY) begin
                expire = (m_tick == 0);
                m_tick = expire ? I - 1 : m_tick - 1;
                take = exp_req && g;
                if (expire && take) begin coinc++; prev_coinc = 1'b1; end
                m_debt = m_debt + int'(expire) - int'(take);
                if (m_debt > MAXO) m_debt = MAXO;
                if (m_debt == MAXO) sat_hits++;
                if (take) m_busy = T_RC;
                else if (m_busy > 0) m_busy--;
            end
            n++;
            @(negedge clk);
        end
        chk(sat_hits > 0, "R10 saturation reached", 32'(sat_hits), 32'd1);
        chk(coinc >= 2, "R11 expiry with grant", 32'(coinc), 32'd2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog expired got=%0d exp=%0d", n, END_N);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule